// File: doc/BRIEF.md
# Four-Sequencer Sample Controller

The block runs four sample sequencers off one shared trigger input. Each sequencer has an enable bit, a 4-bit trigger-source selector and a 16-entry result queue. When a one-cycle pulse arrives on the trigger input, every sequencer that is enabled and whose selector holds code 5 takes one sample. The sequencers are served in ascending index order within that single cycle. Each sample is pushed into the sequencer's own queue, and the sequencer's raw event bit is set. Each sequencer drives its own interrupt line, which is gated by a mask bit.

No analog converter is present. A 32-bit linear congruential generator stands in for it. The generator steps once for every sample taken, before the sample is formed, so results vary from sample to sample. Software reaches all state through a small word-addressed register port. Reading a sequencer's data register removes the oldest result from its queue. Status flags are cleared by writing 1 to them.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The enable register at address 0x00 keeps only write-data bits [3:0]. Bit n enables sequencer n, any combination may be set, and the upper read bits are 0.
- R2: A trigger pulse leaves sequencer n untouched unless enable bit n is 1 and bits [4n+3:4n] of the selector register at 0x18 equal 5. An untouched sequencer has no queue entry and no raw bit.
- R3: Per trigger, the selected sequencers are taken in order 0 to 3. Before each sample, the noise state steps to state*314159+1, modulo 2^32. The stored 12-bit sample is 0x200 plus bits [18:16] of the stepped state.
- R4: Each queue holds 16 results and returns them oldest first through its data register at 0x20+4n. Each read removes the returned entry.
- R5: A sample that meets a full queue is dropped, and bit n of the overflow register at 0x10 is set. Writing 1 to a bit of 0x10 clears that bit.
- R6: Every selected sequencer sets raw bit n at 0x04 in the cycle after the trigger, whether or not its sample was stored. Output irq[n] is high exactly when raw bit n and mask bit n (mask register at 0x08) are both 1.
- R7: Writing 1 to a bit of the clear register at 0x0C clears that raw bit. Reading 0x0C returns raw AND mask.
- R8: Reading an empty queue returns the value last removed from that queue, or 0 if none has been removed. It moves nothing and sets bit n of the underflow register at 0x14. Writing 1 to a bit of 0x14 clears that bit.
- R9: Reset empties all queues and clears the enable, mask, selector, raw, overflow and underflow registers. It also sets the noise state to 0, so the first sample after reset is 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| trigIn | input | 1 | One-cycle sample trigger |
| irq | output | 4 | Per-sequencer masked interrupt |

## Verification
The hardest situation to reach is a queue overflowing while its neighbours stay untouched. The stimulus enables sequencer 3 alone and fires seventeen triggers. The seventeenth still steps the noise state, so the bench model must step its state for the dropped sample too. Otherwise every later expected value would be wrong. The run then drains the queue one read past empty, which exercises the hold-last-value underflow path. A second reset in the middle of the run shows that the noise seed returns to 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEQ_COUNT = 4;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] TRIG_CODE = 4'd5;
  localparam logic [31:0] NOISE_MULT = 32'd314159;
  localparam int NOISE_LSB = 16;
  localparam int NOISE_BITS = 3;
  localparam int SAMPLE_BASE = 'h200;

  localparam logic [7:0] ADDR_ENABLE = 8'h00;
  localparam logic [7:0] ADDR_RAW = 8'h04;
  localparam logic [7:0] ADDR_MASK = 8'h08;
  localparam logic [7:0] ADDR_CLR = 8'h0C;
  localparam logic [7:0] ADDR_OVF = 8'h10;
  localparam logic [7:0] ADDR_UDF = 8'h14;
  localparam logic [7:0] ADDR_SEL = 8'h18;
  localparam logic [3:0] FIFO_PAGE = 4'h2;

  typedef struct packed {
    logic [SEQ_COUNT-1:0] push;
    logic [SEQ_COUNT-1:0] pop;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  seqStrobe_t strobe,
  output logic [SEQ_COUNT-1:0] fullVec,
  output logic [SEQ_COUNT-1:0] emptyVec,
  output logic [SEQ_COUNT-1:0][SAMPLE_W-1:0] fifoData
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [31:0] noiseState;
  logic [31:0] chain [SEQ_COUNT+1];
  logic [SAMPLE_W-1:0] sample [SEQ_COUNT];

  always_comb begin
    chain[0] = noiseState;
    for (int n = 0; n < SEQ_COUNT; n++) begin
      chain[n+1] = strobe.push[n] ? (chain[n] * NOISE_MULT + 32'd1) : chain[n];
      sample[n] = SAMPLE_W'(SAMPLE_BASE) +
                  SAMPLE_W'(chain[n+1][NOISE_LSB +: NOISE_BITS]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) noiseState <= 32'd0;
    else       noiseState <= chain[SEQ_COUNT];
  end

  for (genvar n = 0; n < SEQ_COUNT; n++) begin : g_seq
    logic [SAMPLE_W-1:0] store [DEPTH];
    logic [PW-1:0] headP, tailP;
    logic [CW-1:0] count;
    logic [SAMPLE_W-1:0] lastOut;
    logic doPush, doPop;

    assign fullVec[n]  = (count == CW'(DEPTH));
    assign emptyVec[n] = (count == '0);
    assign doPush = strobe.push[n] && !fullVec[n];
    assign doPop  = strobe.pop[n] && !emptyVec[n];
    assign fifoData[n] = emptyVec[n] ? lastOut : store[tailP];

    always_ff @(posedge clk) begin
      if (doPush) store[headP] <= sample[n];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headP <= '0;
        tailP <= '0;
        count <= '0;
        lastOut <= '0;
      end else begin
        if (doPush) headP <= headP + 1'b1;
        if (doPop) begin
          tailP <= tailP + 1'b1;
          lastOut <= store[tailP];
        end
        count <= count + CW'(doPush) - CW'(doPop);
      end
    end

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fullVec[n] && strobe.push[n] && !strobe.pop[n]) |=> fullVec[n]);

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (emptyVec[n] && strobe.pop[n] && !strobe.push[n]) |=>
        (emptyVec[n] && $stable(fifoData[n])));
  end
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [7:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic trigIn,
  input  logic [SEQ_COUNT-1:0] fullVec,
  input  logic [SEQ_COUNT-1:0] emptyVec,
  input  logic [SEQ_COUNT-1:0][SAMPLE_W-1:0] fifoData,
  output seqStrobe_t strobe,
  output logic [SEQ_COUNT-1:0] irq
);
  localparam int IDX_W = $clog2(SEQ_COUNT);

  logic [SEQ_COUNT-1:0] enReg, maskReg, rawStat, ovfFlag, udfFlag, hitVec;
  logic [SEL_W*SEQ_COUNT-1:0] selReg;
  logic wrEn, rdEn, fifoHit;
  logic [IDX_W-1:0] fifoIdx;
  logic [SEQ_COUNT-1:0] clrRaw, clrOvf, clrUdf;

  assign wrEn = busSel && busWr;
  assign rdEn = busSel && !busWr;
  assign fifoHit = (busAddr[7:4] == FIFO_PAGE);
  assign fifoIdx = busAddr[2 +: IDX_W];

  for (genvar n = 0; n < SEQ_COUNT; n++) begin : g_hit
    assign hitVec[n] = enReg[n] && (selReg[SEL_W*n +: SEL_W] == TRIG_CODE);
  end

  assign strobe.push = trigIn ? hitVec : '0;
  assign strobe.pop  = (rdEn && fifoHit) ? (SEQ_COUNT'(1) << fifoIdx) : '0;

  assign clrRaw = (wrEn && busAddr == ADDR_CLR) ? busWdata[SEQ_COUNT-1:0] : '0;
  assign clrOvf = (wrEn && busAddr == ADDR_OVF) ? busWdata[SEQ_COUNT-1:0] : '0;
  assign clrUdf = (wrEn && busAddr == ADDR_UDF) ? busWdata[SEQ_COUNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      maskReg <= '0;
      selReg <= '0;
      rawStat <= '0;
      ovfFlag <= '0;
      udfFlag <= '0;
    end else begin
      if (wrEn && busAddr == ADDR_ENABLE) enReg <= busWdata[SEQ_COUNT-1:0];
      if (wrEn && busAddr == ADDR_MASK) maskReg <= busWdata[SEQ_COUNT-1:0];
      if (wrEn && busAddr == ADDR_SEL) selReg <= busWdata[SEL_W*SEQ_COUNT-1:0];
      rawStat <= (rawStat & ~clrRaw) | strobe.push;
      ovfFlag <= (ovfFlag & ~clrOvf) | (strobe.push & fullVec);
      udfFlag <= (udfFlag & ~clrUdf) | (strobe.pop & emptyVec);
    end
  end

  assign irq = rawStat & maskReg;

  always_comb begin
    busRdata = '0;
    if (fifoHit) busRdata = 32'(fifoData[fifoIdx]);
    else begin
      case (busAddr)
        ADDR_ENABLE: busRdata = 32'(enReg);
        ADDR_RAW:    busRdata = 32'(rawStat);
        ADDR_MASK:   busRdata = 32'(maskReg);
        ADDR_CLR:    busRdata = 32'(rawStat & maskReg);
        ADDR_OVF:    busRdata = 32'(ovfFlag);
        ADDR_UDF:    busRdata = 32'(udfFlag);
        ADDR_SEL:    busRdata = 32'(selReg);
        default:     busRdata = '0;
      endcase
    end
  end

  // R6
  trig_sets_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && |hitVec) |=> ((rawStat & $past(hitVec)) == $past(hitVec)));

  // R5
  ovf_on_full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.push & fullVec)) |=>
      ((ovfFlag & $past(strobe.push & fullVec)) == $past(strobe.push & fullVec)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWr,
  input  logic [7:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic trigIn,
  output logic [SEQ_COUNT-1:0] irq
);
  seqStrobe_t strobe;
  logic [SEQ_COUNT-1:0] fullVec, emptyVec;
  logic [SEQ_COUNT-1:0][SAMPLE_W-1:0] fifoData;

  adc_seq_ctl #(.SAMPLE_W(SAMPLE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .trigIn(trigIn), .fullVec(fullVec), .emptyVec(emptyVec),
    .fifoData(fifoData), .strobe(strobe), .irq(irq)
  );

  adc_seq_dp #(.DEPTH(FIFO_DEPTH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fullVec(fullVec), .emptyVec(emptyVec), .fifoData(fifoData)
  );
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, trigIn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0] irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int unsigned mNoise = 0;
  logic [3:0] mEn = 0, mMask = 0, mRaw = 0, mOvf = 0, mUdf = 0;
  logic [15:0] mSel = 0;
  logic [11:0] expQ [4][$];
  logic [11:0] lastVal [4];

  always #2.5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .trigIn(trigIn), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mNoise = 0; mEn = 0; mMask = 0; mRaw = 0; mOvf = 0; mUdf = 0; mSel = 0;
    for (int n = 0; n < 4; n++) begin
      expQ[n].delete();
      lastVal[n] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    modelReset();
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
    if (a == 8'h00) mEn = d[3:0];
    if (a == 8'h08) mMask = d[3:0];
    if (a == 8'h18) mSel = d[15:0];
    if (a == 8'h0C) mRaw &= ~d[3:0];
    if (a == 8'h10) mOvf &= ~d[3:0];
    if (a == 8'h14) mUdf &= ~d[3:0];
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  // driver: pulses the trigger and pushes expected samples (R2, R3, R5, R6)
  task automatic trigger();
    @(negedge clk); trigIn = 1;
    @(negedge clk); trigIn = 0;
    for (int n = 0; n < 4; n++) begin
      if (mEn[n] && mSel[4*n +: 4] == 4'd5) begin
        mNoise = mNoise * 314159 + 1;
        if (expQ[n].size() < 16) expQ[n].push_back(12'h200 + 12'((mNoise >> 16) & 7));
        else mOvf[n] = 1;
        mRaw[n] = 1;
      end
    end
  endtask

  // monitor: pops one result and compares it with the scoreboard (R3, R4, R8)
  task automatic readFifo(int n, string req);
    logic [31:0] d;
    logic [11:0] exp;
    busRead(8'h20 + 8'(4 * n), d);
    if (expQ[n].size() > 0) begin
      exp = expQ[n].pop_front();
      lastVal[n] = exp;
    end else begin
      exp = lastVal[n];
      mUdf[n] = 1;
    end
    check(req, d, 32'(exp));
  endtask

  task automatic checkReg(logic [7:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    doReset();
    // R9 reset state
    checkReg(8'h00, 0, "R9 enable after reset");
    checkReg(8'h04, 0, "R9 raw after reset");
    check("R9 irq after reset", 32'(irq), 0);

    // R1 only low four bits kept
    busWrite(8'h00, 32'hFFFF_FFF5);
    checkReg(8'h00, 32'h5, "R1 enable width");

    // R2 gating: seq1 wrong code, seq3 disabled
    busWrite(8'h18, 32'h5535);
    trigger(); trigger(); trigger();
    checkReg(8'h04, 32'(mRaw), "R2 raw after gated triggers");
    check("R2 raw value", 32'(mRaw), 32'h5);
    busWrite(8'h08, 32'h4);
    #1 check("R6 irq masked", 32'(irq), 32'h4);
    checkReg(8'h0C, 32'h4, "R7 masked status read");
    readFifo(1, "R2 untouched sequencer returns reset value");
    checkReg(8'h14, 32'h2, "R8 underflow set");
    readFifo(3, "R2 disabled sequencer empty");
    for (int i = 0; i < 3; i++) begin
      readFifo(0, "R3 seq0 sample");
      readFifo(2, "R3 seq2 sample");
    end
    busWrite(8'h14, 32'hF);
    checkReg(8'h14, 0, "R8 underflow cleared");

    // R3 all four in ascending order
    busWrite(8'h00, 32'hF);
    busWrite(8'h18, 32'h5555);
    trigger(); trigger();
    for (int n = 0; n < 4; n++) begin
      readFifo(n, "R3 ordered sample first");
      readFifo(n, "R3 ordered sample second");
    end
    busWrite(8'h08, 32'hF);
    #1 check("R6 irq all", 32'(irq), 32'hF);

    // R7 clear raw bits selectively then fully
    busWrite(8'h0C, 32'h3);
    checkReg(8'h04, 32'hC, "R7 partial clear");
    busWrite(8'h0C, 32'hF);
    checkReg(8'h04, 0, "R7 full clear");
    #1 check("R6 irq low after clear", 32'(irq), 0);

    // R4/R5 overflow on sequencer 3 alone
    busWrite(8'h14, 32'hF);
    busWrite(8'h00, 32'h8);
    for (int i = 0; i < 16; i++) trigger();
    checkReg(8'h10, 0, "R5 no overflow at exactly full");
    trigger();
    checkReg(8'h10, 32'h8, "R5 overflow set");
    checkReg(8'h04, 32'h8, "R6 raw set on dropped sample");
    for (int i = 0; i < 16; i++) readFifo(3, "R4 fifo order");
    readFifo(3, "R8 empty read returns last value");
    checkReg(8'h14, 32'h8, "R8 underflow seq3");
    busWrite(8'h10, 32'h8);
    checkReg(8'h10, 0, "R5 overflow cleared");
    trigger();
    readFifo(3, "R5 sample after overflow uses advanced noise");

    // R9 reset mid-run reseeds noise
    trigger();
    doReset();
    checkReg(8'h04, 0, "R9 raw cleared");
    checkReg(8'h10, 0, "R9 overflow cleared");
    readFifo(3, "R9 fifo emptied");
    busWrite(8'h14, 32'hF);
    busWrite(8'h00, 32'h1);
    busWrite(8'h18, 32'h5);
    trigger();
    busRead(8'h20, d);
    check("R9 first sample after reset", d, 32'h200);
    void'(expQ[0].pop_front());
    trigger();
    readFifo(0, "R3 second sample after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule